// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a system watchdog reached through a small word-wide register port. A slow tick, produced from the core clock by a prescaler, decrements a 10-bit counter. A tick that arrives while the counter already reads zero is an expiry. On every expiry the counter reloads itself from the programmed timeout and keeps counting.

The first expiry sets a sticky timeout flag and, when the SMI gate input is high, emits a one-cycle SMI pulse. An expiry that finds the timeout flag still set records a second-timeout flag and emits a one-cycle system-reset request. The reset request is suppressed while the reboot-inhibit input is high. Software keeps the system alive in one of two ways: it writes the reload register before the counter runs out, or it clears the timeout flag between expiries so that two more full periods are needed.

After reset the counter is halted. Software programs a timeout, clears the halt bit in the control register and then writes the reload register periodically. Status flags are cleared by writing 1 to them.

Top module: `dual_expiry_wdt`

## Requirements
- R1: After reset the control register reads 0x0800 (halt set), the timeout register reads the default 50, both status registers read 0, and `smi_pulse` and `sys_rst_req` are low.
- R2: The registers are decoded on byte address `addr`, and reads return data only while `rd_en` is high:
  - 0x00: counter, bits 9:0.
  - 0x04: status A, with the timeout flag in bit 3.
  - 0x06: status B, with the second-timeout flag in bit 1 and the boot flag in bit 2.
  - 0x08: control, with halt in bit 11.
  - 0x12: timeout value, bits 9:0.
  - Any other address reads 0.
- R3: A write to 0x12 whose bits 9:0 hold 0 to 3 is ignored and the previous value is kept. Any other value is stored from bits 9:0 and reads back exactly; bits 15:10 are dropped.
- R4: While halt is 1 neither the counter nor the prescaler advances, and no expiry occurs.
- R5: With halt at 0 the counter decrements once every TICK_DIV clocks. Any write to 0x00, whatever its data, loads the counter from the timeout value and restarts the prescaler.
- R6: A tick while the counter reads 0 is an expiry, and it reloads the counter from the timeout value. Expiries are therefore (timeout+1)·TICK_DIV clocks apart, and the first one comes that long after a reload write.
- R7: An expiry with the timeout flag clear sets that flag. It raises `smi_pulse` for exactly the one cycle after the expiry edge, but only if `smi_gate` was high at that edge.
- R8: An expiry with the timeout flag set sets the second-timeout flag and raises `sys_rst_req` for exactly one cycle. The same edge sets the boot flag. No SMI is produced.
- R9: The status flags clear only when 1 is written to their bit, and writing 0 leaves them unchanged. Once the timeout flag is cleared, the next expiry is again a first expiry.
- R10: While `reboot_inhibit` is high, a second expiry sets the second-timeout flag but neither requests a reset nor sets the boot flag.
- R11: A reload write in the same cycle as an expiring tick wins. The counter loads the timeout value and no expiry, flag or pulse results.
- R12: An expiry in the same cycle as a write of 1 to the timeout flag leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read enable |
| addr | input | 5 | Byte address inside the 32-byte window |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from addr |
| smi_gate | input | 1 | Allows the first expiry to signal SMI |
| reboot_inhibit | input | 1 | Suppresses the reset request |
| smi_pulse | output | 1 | One-cycle SMI event |
| sys_rst_req | output | 1 | One-cycle system-reset request |

## Verification
Two pairs of events can share a clock edge. The first pair is a reload write and the tick that would expire the counter. The second pair is a write-one-to-clear of the timeout flag and an expiry. The bench counts clock edges from the last reload and places each write on the exact expiry edge. For the first pair it then judges the SMI and reset outputs, the counter read-back and the flag. For the second pair it checks that the flag is still set and that the SMI pulse was not lost. The rest of the checks are randomized timeouts, SMI gating and reboot-inhibit settings, and each is judged against an edge count computed from the requirements.

// File: rtl/dual_expiry_wdt.sv
module dual_expiry_wdt #(
  parameter int TICK_DIV = 75_000_000,
  parameter int CNT_W    = 10,
  parameter int INIT_DEF = 50,
  parameter int INIT_MIN = 4,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              smi_gate,
  input  logic              reboot_inhibit,
  output logic              smi_pulse,
  output logic              sys_rst_req
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PRESC_LAST = PW'(TICK_DIV - 1);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_STSA = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_STSB = ADDR_W'(8'h06);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_INIT = ADDR_W'(8'h12);
  localparam int B_TO   = 3;
  localparam int B_SEC  = 1;
  localparam int B_BOOT = 2;
  localparam int B_HALT = 11;

  logic [PW-1:0]    presc_q;
  logic [CNT_W-1:0] cnt_q, init_q;
  logic halt_q, to_q, sec_q, boot_q, smi_q, rst_q;
  logic [DATA_W-1:0] rd_mux;
  logic unused_bits;

  wire wr_cnt  = wr_en && addr == A_CNT;
  wire wr_stsa = wr_en && addr == A_STSA;
  wire wr_stsb = wr_en && addr == A_STSB;
  wire wr_ctrl = wr_en && addr == A_CTRL;
  wire wr_init = wr_en && addr == A_INIT;

  wire tick       = !halt_q && presc_q == PRESC_LAST;
  wire expire     = tick && cnt_q == '0 && !wr_cnt;
  wire first_exp  = expire && !to_q;
  wire second_exp = expire && to_q;
  wire init_ok    = wdata[CNT_W-1:0] >= CNT_W'(INIT_MIN);
  wire clr_to     = wr_stsa && wdata[B_TO];
  wire clr_sec    = wr_stsb && wdata[B_SEC];
  wire clr_boot   = wr_stsb && wdata[B_BOOT];

  assign unused_bits = ^wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc_q <= '0;
      cnt_q   <= CNT_W'(INIT_DEF);
      init_q  <= CNT_W'(INIT_DEF);
      halt_q  <= 1'b1;
      to_q    <= 1'b0;
      sec_q   <= 1'b0;
      boot_q  <= 1'b0;
      smi_q   <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      if (halt_q || wr_cnt || tick) presc_q <= '0;
      else                          presc_q <= presc_q + 1'b1;
      if (wr_cnt)                   cnt_q <= init_q;
      else if (tick)                cnt_q <= (cnt_q == '0) ? init_q : cnt_q - 1'b1;
      if (wr_init && init_ok)       init_q <= wdata[CNT_W-1:0];
      if (wr_ctrl)                  halt_q <= wdata[B_HALT];
      to_q   <= expire | (to_q & ~clr_to);
      sec_q  <= second_exp | (sec_q & ~clr_sec);
      boot_q <= (second_exp & ~reboot_inhibit) | (boot_q & ~clr_boot);
      smi_q  <= first_exp & smi_gate;
      rst_q  <= second_exp & ~reboot_inhibit;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_CNT:  rd_mux[CNT_W-1:0] = cnt_q;
      A_STSA: rd_mux[B_TO] = to_q;
      A_STSB: begin rd_mux[B_SEC] = sec_q; rd_mux[B_BOOT] = boot_q; end
      A_CTRL: rd_mux[B_HALT] = halt_q;
      A_INIT: rd_mux[CNT_W-1:0] = init_q;
      default: ;
    endcase
  end

  assign rdata       = rd_en ? rd_mux : '0;
  assign smi_pulse   = smi_q;
  assign sys_rst_req = rst_q;

  // R3
  init_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_q >= CNT_W'(INIT_MIN));
  // R4
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !wr_cnt) |=> $stable(cnt_q));
  // R5
  reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt_q == $past(init_q));
  // R7
  smi_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smi_pulse |-> $past(smi_gate) && !sys_rst_req);
  // R8
  rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> !sys_rst_req);
  // R8
  rst_prior_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> $past(to_q) && boot_q && sec_q);
  // R10
  rst_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> !$past(reboot_inhibit));
endmodule

// File: tb/dual_expiry_wdt_tb.sv
module dual_expiry_wdt_tb_top;
  localparam int DIV = 3;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic smi_gate = 1'b1, reboot_inhibit = 1'b0;
  logic smi_pulse, sys_rst_req;
  int n_vec = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dual_expiry_wdt #(.TICK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .smi_gate(smi_gate),
    .reboot_inhibit(reboot_inhibit), .smi_pulse(smi_pulse), .sys_rst_req(sys_rst_req));

  function automatic int period(int init);
    return (init + 1) * DIV;
  endfunction
  function automatic int stsb_after_second(bit inh);
    return inh ? 32'h2 : 32'h6;
  endfunction
  function automatic int accepted_init(int prev, int wr);
    return ((wr & 32'h3FF) < 4) ? prev : (wr & 32'h3FF);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output int v);
    rd_en = 1'b1; addr = a;
    #1 v = int'(rdata);
    rd_en = 1'b0;
  endtask

  task automatic rdchk(logic [4:0] a, int exp, string tag);
    int v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic expect_at(int e, bit smi_e, bit rst_e, string tag);
    while (cyc < e - 1) @(negedge clk);
    chk({tag, " quiet before expiry"}, int'({smi_pulse, sys_rst_req}), 0);
    @(negedge clk);
    chk({tag, " smi"}, int'(smi_pulse), int'(smi_e));
    chk({tag, " reset"}, int'(sys_rst_req), int'(rst_e));
    @(negedge clk);
    chk({tag, " single cycle"}, int'({smi_pulse, sys_rst_req}), 0);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
  end

  initial begin
    int e, w, v1, ini, prev;
    bit g, inh;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rdchk(5'h12, 50, "R1 timeout default");
    rdchk(5'h08, 32'h0800, "R1 halt set");
    rdchk(5'h04, 0, "R1 status A clear");
    rdchk(5'h06, 0, "R1 status B clear");
    chk("R1 outputs low", int'({smi_pulse, sys_rst_req}), 0);
    // R2 unused address and read enable
    rdchk(5'h0A, 0, "R2 unused address");
    chk("R2 no rd_en", int'(rdata), 0);
    // R3 minimum rule and masking
    prev = 50;
    wr(5'h12, 16'h0002); prev = accepted_init(prev, 2);
    rdchk(5'h12, prev, "R3 write 2 ignored");
    wr(5'h12, 16'h0003); prev = accepted_init(prev, 3);
    rdchk(5'h12, prev, "R3 write 3 ignored");
    wr(5'h12, 16'hFC07); prev = accepted_init(prev, 32'hFC07);
    rdchk(5'h12, prev, "R3 upper bits dropped");
    wr(5'h12, 16'h03FF);
    rdchk(5'h12, 32'h3FF, "R3 maximum");
    wr(5'h12, 16'h0004);
    rdchk(5'h12, 4, "R3 minimum accepted");
    // R4 halted counter stays put
    wr(5'h12, 16'd8);
    wr(5'h00, 16'h0000);
    rdchk(5'h00, 8, "R4 loaded while halted");
    repeat (40) @(negedge clk);
    rdchk(5'h00, 8, "R4 frozen while halted");
    chk("R4 no event while halted", int'({smi_pulse, sys_rst_req}), 0);
    // R5 counting
    wr(5'h08, 16'h0000);
    wr(5'h00, 16'h1234);
    w = cyc;
    while (cyc < w + 3 * DIV) @(negedge clk);
    rdchk(5'h00, 5, "R5 three ticks");
    // R6 R7 first expiry
    e = w + period(8);
    expect_at(e, 1'b1, 1'b0, "R7 first expiry");
    rdchk(5'h00, 8, "R6 auto reload");
    rdchk(5'h04, 32'h8, "R7 timeout flag");
    // R8 second expiry
    e = e + period(8);
    expect_at(e, 1'b0, 1'b1, "R8 second expiry");
    rdchk(5'h06, 32'h6, "R8 second and boot flags");
    rdchk(5'h04, 32'h8, "R8 timeout flag kept");
    // R9 write one to clear
    wr(5'h06, 16'h0000);
    rdchk(5'h06, 32'h6, "R9 write zero no effect");
    wr(5'h06, 16'h0002);
    rdchk(5'h06, 32'h4, "R9 clear second flag");
    wr(5'h06, 16'h0004);
    rdchk(5'h06, 0, "R9 clear boot flag");
    wr(5'h04, 16'h0008);
    rdchk(5'h04, 0, "R9 clear timeout flag");
    e = e + period(8);
    expect_at(e, 1'b1, 1'b0, "R9 cleared flag restarts two stages");
    // R10 inhibit
    reboot_inhibit = 1'b1;
    e = e + period(8);
    expect_at(e, 1'b0, 1'b0, "R10 inhibited second expiry");
    rdchk(5'h06, stsb_after_second(1'b1), "R10 second flag only");
    reboot_inhibit = 1'b0;
    wr(5'h06, 16'h0006);
    wr(5'h04, 16'h0008);
    // R11 reload on the expiring tick
    e = e + period(8);
    while (cyc < e - 1) @(negedge clk);
    wr(5'h00, 16'h0000);
    chk("R11 no smi on collision", int'({smi_pulse, sys_rst_req}), 0);
    rdchk(5'h00, 8, "R11 counter reloaded");
    rdchk(5'h04, 0, "R11 no flag");
    e = cyc + period(8);
    expect_at(e, 1'b1, 1'b0, "R11 restarted period");
    // R12 clear on the expiring edge
    wr(5'h04, 16'h0008);
    e = e + period(8);
    while (cyc < e - 1) @(negedge clk);
    wr(5'h04, 16'h0008);
    chk("R12 smi on collision", int'(smi_pulse), 1);
    rdchk(5'h04, 32'h8, "R12 flag survives clear");
    // R4 halt while running
    wr(5'h08, 16'h0800);
    rd(5'h00, v1);
    repeat (3 * period(8)) @(negedge clk);
    rdchk(5'h00, v1, "R4 halted mid-run");
    chk("R4 no event mid-run halt", int'({smi_pulse, sys_rst_req}), 0);
    wr(5'h08, 16'h0000);
    // random timeouts, gating and inhibit
    for (int i = 0; i < 30; i++) begin
      ini = 4 + int'($urandom % 24);
      g = 1'($urandom % 2);
      inh = 1'($urandom % 2);
      smi_gate = g;
      reboot_inhibit = inh;
      wr(5'h04, 16'h0008);
      wr(5'h06, 16'h0006);
      wr(5'h12, 16'(ini));
      wr(5'h00, 16'h0000);
      e = cyc + period(ini);
      expect_at(e, g, 1'b0, "R7 random first");
      rdchk(5'h04, 32'h8, "R7 random flag");
      e = e + period(ini);
      expect_at(e, 1'b0, !inh, "R8 R10 random second");
      rdchk(5'h06, stsb_after_second(inh), "R10 random status B");
    end
    summary();
  end
endmodule